// File: doc/BRIEF.md
# Keyboard Port Address Decoder

This block sits between a processor's memory bus and main memory. It claims two bus addresses, a keyboard status word at 0xFE00 and a keyboard character word at 0xFE02, and passes every other access through to memory unchanged. Characters arrive on a byte-wide valid/ready stream.

The status word and the character register are not refreshed on their own. They change only when software reads the status address. If a character is waiting at that moment, the read returns a word with only the top bit set. The waiting character is accepted from the stream in that same cycle and stored. A later read of 0xFE02 returns the stored character, zero-extended. If nothing is waiting, the status read returns zero and the stored character is kept.

Bus reads are combinational: the read data belongs to the cycle in which `bus_rd` is high. The character register updates on the clock edge that ends a status read.

Top module: `kbd_port_decode`

## Requirements
- R1: A read (`bus_rd`=1) of address 0xFE00 while `key_valid`=1 returns 0x8000 (bit 15 only) on `bus_rdata`. It asserts `key_ready` in that same cycle, and the clock edge that ends the cycle loads `key_data` into the character register.
- R2: A read of 0xFE00 while `key_valid`=0 returns 0x0000. It leaves `key_ready` low and the character register unchanged.
- R3: A read of 0xFE02 returns the stored character in bits 7:0 with bits 15:8 zero. It does not assert `key_ready`.
- R4: `key_ready` is high only during a read of 0xFE00 with `key_valid` high. A character offered at any other time stays pending.
- R5: A read of any address other than 0xFE00 and 0xFE02 returns `mem_rdata` unchanged.
- R6: Writes (`bus_wr`=1) to 0xFE00 or 0xFE02 keep `mem_wr` low and do not change the character register. Writes to any other address drive `mem_wr` high.
- R7: After reset the character register holds zero, so a read of 0xFE02 returns 0x0000.
- R8: The decode compares all 16 address bits. Neighbouring addresses such as 0xFE01, 0xFE03 and 0x7E00 are passed through to memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus address |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_rdata | output | 16 | Read data returned to the processor |
| mem_rdata | input | 16 | Read data from main memory |
| mem_wr | output | 1 | Write strobe forwarded to main memory |
| key_data | input | 8 | Character offered by the stream |
| key_valid | input | 1 | Stream character is available |
| key_ready | output | 1 | Stream character is accepted this cycle |

## Verification
Two events can fall in the same cycle: accepting a character from the stream, and the source putting a new character on the stream right after. The bench provokes this with back-to-back status reads while `key_valid` stays high and `key_data` changes every cycle. Each read must show its own handshake, and a following read of 0xFE02 must return the character from the last status read. Random traffic also offers characters during data reads, writes and memory reads. The bench's own model is compared against the outputs on every cycle, so any consumption outside a status read, and any character the register fails to take, appears as a mismatch.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int unsigned ADDR_W_DEF = 16;
  localparam int unsigned DATA_W_DEF = 16;
  localparam int unsigned CHAR_W_DEF = 8;

  typedef enum logic [1:0] {
    SRC_MEM  = 2'd0,
    SRC_STAT = 2'd1,
    SRC_CHAR = 2'd2
  } rd_src_e;
endpackage

// File: rtl/kbd_addr_match.sv
module kbd_addr_match #(
  parameter int unsigned ADDR_W = kbd_pkg::ADDR_W_DEF,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'hFE00,
  parameter logic [ADDR_W-1:0] CHAR_ADDR = 'hFE02
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              stat_hit,
  output logic              char_hit,
  output kbd_pkg::rd_src_e  src
);
  always_comb begin
    stat_hit = (addr == STAT_ADDR);
    char_hit = (addr == CHAR_ADDR);
    if (stat_hit)      src = kbd_pkg::SRC_STAT;
    else if (char_hit) src = kbd_pkg::SRC_CHAR;
    else               src = kbd_pkg::SRC_MEM;
  end
endmodule

// File: rtl/kbd_char_latch.sv
module kbd_char_latch #(
  parameter int unsigned CHAR_W = kbd_pkg::CHAR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [CHAR_W-1:0] char_in,
  output logic [CHAR_W-1:0] char_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    char_q <= '0;
    else if (take) char_q <= char_in;
  end

  AST_LOAD_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> char_q == $past(char_in)); // R1
  AST_HOLD_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(char_q)); // R2
endmodule

// File: rtl/kbd_read_mux.sv
module kbd_read_mux #(
  parameter int unsigned DATA_W = kbd_pkg::DATA_W_DEF,
  parameter int unsigned CHAR_W = kbd_pkg::CHAR_W_DEF
) (
  input  kbd_pkg::rd_src_e  src,
  input  logic              avail,
  input  logic [CHAR_W-1:0] char_q,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned PAD_W = DATA_W - CHAR_W;

  function automatic logic [DATA_W-1:0] status_word(input logic flag);
    return {flag, {(DATA_W-1){1'b0}}};
  endfunction

  function automatic logic [DATA_W-1:0] widen(input logic [CHAR_W-1:0] c);
    return {{PAD_W{1'b0}}, c};
  endfunction

  always_comb begin
    unique case (src)
      kbd_pkg::SRC_STAT: rdata = status_word(avail);
      kbd_pkg::SRC_CHAR: rdata = widen(char_q);
      default:           rdata = mem_rdata;
    endcase
  end
endmodule

// File: rtl/kbd_port_decode.sv
module kbd_port_decode #(
  parameter int unsigned ADDR_W = kbd_pkg::ADDR_W_DEF,
  parameter int unsigned DATA_W = kbd_pkg::DATA_W_DEF,
  parameter int unsigned CHAR_W = kbd_pkg::CHAR_W_DEF,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'hFE00,
  parameter logic [ADDR_W-1:0] CHAR_ADDR = 'hFE02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_wr,
  input  logic [CHAR_W-1:0] key_data,
  input  logic              key_valid,
  output logic              key_ready
);
  logic             stat_hit;
  logic             char_hit;
  logic             take_char;
  logic [CHAR_W-1:0] char_q;
  kbd_pkg::rd_src_e rd_src;

  kbd_addr_match #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .CHAR_ADDR(CHAR_ADDR)) u_match (
    .addr(bus_addr), .stat_hit(stat_hit), .char_hit(char_hit), .src(rd_src)
  );

  assign take_char = bus_rd && stat_hit && key_valid;
  assign key_ready = take_char;
  assign mem_wr    = bus_wr && !(stat_hit || char_hit);

  kbd_char_latch #(.CHAR_W(CHAR_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .take(take_char), .char_in(key_data), .char_q(char_q)
  );

  kbd_read_mux #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_mux (
    .src(rd_src), .avail(key_valid), .char_q(char_q), .mem_rdata(mem_rdata), .rdata(bus_rdata)
  );

  AST_READY_ONLY_ON_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    key_ready |-> (bus_rd && key_valid && bus_addr == STAT_ADDR)); // R4
  AST_EMPTY_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == STAT_ADDR && !key_valid) |-> (bus_rdata == '0 && !key_ready)); // R2
  AST_CHAR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == CHAR_ADDR) |-> (bus_rdata[DATA_W-1:CHAR_W] == '0 && !key_ready)); // R3
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != STAT_ADDR && bus_addr != CHAR_ADDR) |-> bus_rdata == mem_rdata); // R5
  AST_NO_PERIPH_MEMWR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == STAT_ADDR || bus_addr == CHAR_ADDR) |-> !mem_wr); // R6
endmodule

// File: tb/sim_kbd_port_decode.sv
`timescale 1ns/1ps
module sim_kbd_port_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_rdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_wr;
  logic [7:0]  key_data = '0;
  logic        key_valid = 1'b0;
  logic        key_ready;

  int n_cmp = 0;
  int n_bad = 0;
  int ref_char = 0;

  always #2.5 clk = ~clk;

  kbd_port_decode u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .mem_rdata(mem_rdata), .mem_wr(mem_wr),
    .key_data(key_data), .key_valid(key_valid), .key_ready(key_ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h addr=%h", req, act, exp, bus_addr);
    end
  endtask

  // One bus cycle: drive at the falling edge, compare against the model, update the model.
  task automatic cyc(input int a, input bit rd, input bit wr, input int kd, input bit kv, input int md);
    int exp_rd;
    bit is_stat, is_char, exp_take;
    @(negedge clk);
    bus_addr = 16'(a); bus_rd = rd; bus_wr = wr;
    key_data = 8'(kd); key_valid = kv; mem_rdata = 16'(md);
    #1;
    is_stat = (a == 'hFE00);
    is_char = (a == 'hFE02);
    exp_take = rd && is_stat && kv;
    if (rd) begin
      if (is_stat)      exp_rd = kv ? 'h8000 : 0;
      else if (is_char) exp_rd = ref_char;
      else              exp_rd = md & 'hFFFF;
      if (is_stat)      chk(kv ? "R1 status pending" : "R2 status empty", int'(bus_rdata), exp_rd);
      else if (is_char) chk("R3 char read", int'(bus_rdata), exp_rd);
      else              chk("R5/R8 pass-through", int'(bus_rdata), exp_rd);
    end
    chk("R4 key_ready", int'(key_ready), int'(exp_take));
    chk("R6 mem_wr", int'(mem_wr), int'(wr && !is_stat && !is_char));
    if (exp_take) ref_char = kd & 'hFF;
  endtask

  initial begin
    #(100000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R7: zero after reset
    cyc('hFE02, 1, 0, 'h55, 1, 'h1234);
    cyc('hFE00, 1, 0, 'h00, 0, 'h1111);                 // R2
    cyc('hFE00, 1, 0, 'h41, 1, 'h2222);                 // R1
    cyc('hFE02, 1, 0, 'h99, 1, 'h3333);                 // R3, R4: no consume
    cyc('hFE00, 1, 0, 'h99, 0, 'h0);                    // R2 keeps 0x41
    cyc('hFE02, 1, 0, 'h00, 0, 'h0);
    // back-to-back consumption with changing data
    cyc('hFE00, 1, 0, 'hA1, 1, 'h0);
    cyc('hFE00, 1, 0, 'hA2, 1, 'h0);
    cyc('hFE00, 1, 0, 'hFF, 1, 'h0);
    cyc('hFE02, 1, 0, 'h00, 1, 'h0);
    // R6 writes to peripheral addresses
    cyc('hFE00, 0, 1, 'h12, 1, 'h0);
    cyc('hFE02, 0, 1, 'h34, 1, 'h0);
    cyc('hFE02, 1, 0, 'h00, 0, 'h0);
    cyc('h3000, 0, 1, 'h00, 1, 'h0);
    // R8 neighbours
    cyc('hFE01, 1, 0, 'h00, 1, 'hBEEF);
    cyc('hFE03, 1, 0, 'h00, 1, 'hCAFE);
    cyc('h7E00, 1, 0, 'h00, 1, 'hF00D);
    cyc('hFE02, 1, 0, 'h00, 0, 'h0);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int pick, a;
      bit rd;
      pick = int'($urandom_range(0, 5));
      case (pick)
        0, 1:    a = 'hFE00;
        2:       a = 'hFE02;
        3:       a = 'hFE01;
        4:       a = 'hFDFE;
        default: a = int'($urandom_range(0, 'hFFFF));
      endcase
      rd = $urandom_range(0, 3) != 0;
      cyc(a, rd, !rd && $urandom_range(0, 1) == 1, int'($urandom_range(0, 255)),
          $urandom_range(0, 1) == 1, int'($urandom_range(0, 'hFFFF)));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule